// File: doc/BRIEF.md
# Dual-Mode SECDED Protected Array Controller

This block controls a small register-based memory whose every entry stores 64 data bits next to 8 check bits from a single-error-correcting, double-error-detecting code. The code uses odd-weight check columns. The controller can run in one of two protection modes. A mode input selects the mode, and the block adopts it only while the request port is quiet.

In read-checking mode, each read recomputes the code from the stored data and compares it with the stored check bits. A single flipped bit is repaired before the data goes back to the requester. In write-checking mode, reads fetch the data bits only, and both the check-bit read and the decoder stay disabled. Instead, each write is split in two: a full check of the entry about to be overwritten, then the store of the new word and its code. When that pre-write check finds a fault, the block reports it by location:
- a flipped check bit is harmless to the data already consumed;
- a flipped data bit means the enclosing atomic sequence must be discarded and rerun;
- a double fault is uncorrectable.

The block only reports these events; recovery happens elsewhere. An error-injection mask on the write path lets a test corrupt the stored codeword on purpose.

The request port follows valid/ready rules. A requester raises `req_valid` and must hold every request field steady until `req_ready` is high at a clock edge. `req_ready` may fall in response to `req_valid`, and it does so for exactly one cycle on a write in write-checking mode. Read responses and error reports are one-cycle pulses with no back-pressure.

Top module: `ecc_array_ctrl`

## Requirements
- R1: Each write stores the 72-bit codeword {check[7:0], data[63:0]} XORed with `req_inject`. Codeword positions 0 to 63 are data bits and positions 64 to 71 are check bits 0 to 7. The check bits come from an odd-weight-column SECDED code, so an entry written with a zero mask reads back unchanged and without error.
- R2: A read accepted at a clock edge raises `rsp_valid` for one cycle after that edge, with the read data on `rsp_rdata`. Reads are never stalled.
- R3: In read-checking mode, a single-bit fault in either the data or the check bits is corrected in `rsp_rdata` and reported as class 1. A double-bit fault returns the raw stored data and is reported as class 3. A clean read produces no report.
- R4: In write-checking mode, a read returns the raw stored data bits and never raises `err_valid`, even when the entry holds a fault.
- R5: In write-checking mode, a write holds `req_ready` low for the first cycle it is presented and high in the next cycle, when the write is accepted.
- R6: In write-checking mode, the pre-write check of the old entry reports in the cycle `req_ready` returns high. A single flipped check bit gives class 1 (fast-correctable), a single flipped data bit gives class 2 (slow-correctable), and a double fault gives class 3 (uncorrectable). `err_idx` equals the written index. A clean entry gives no report.
- R7: In read-checking mode, a write is accepted in the cycle it is presented and produces no error report.
- R8: A new value on `mode_cow` is adopted only at a clock edge where the controller is idle and `req_valid` is low. A request already presented is served in the mode that was in force.
- R9: After reset, `req_ready` is high, `rsp_valid` and `err_valid` are low, read-checking mode is active, and every entry reads as zero with no error.
- R10: `err_valid` is a single-cycle pulse per detected event, and `err_class` is nonzero whenever `err_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cow | input | 1 | 1 selects write-checking mode, 0 selects read-checking mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high with `req_valid` |
| req_we | input | 1 | 1 for write, 0 for read |
| req_idx | input | IDX_W | Entry index |
| req_wdata | input | 64 | Write data |
| req_inject | input | 72 | Bits to flip in the stored codeword on a write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 64 | Read data |
| err_valid | output | 1 | Error event pulse |
| err_class | output | 2 | 0 none, 1 fast-correctable, 2 slow-correctable, 3 uncorrectable |
| err_idx | output | IDX_W | Index of the faulty entry |

## Verification
The assertions assume the requester obeys the hold rule: once a write has been presented in write-checking mode, the same request stays valid through the stall cycle and into the cycle it is accepted. They also assume `req_idx` addresses an existing entry. The bench drives every request on the falling edge, keeps it until the edge where it is accepted, and uses only indices below the array depth. It changes `mode_cow` only in a cycle with no request, except in the one directed test for R8, where the mode changes at the same moment a request is raised.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_FAST   = 2'd1,
    ERR_SLOW   = 2'd2,
    ERR_UNCORR = 2'd3
  } err_class_e;

  typedef enum logic [1:0] {
    SYN_CLEAN,
    SYN_CHK,
    SYN_DATA,
    SYN_MULTI
  } syn_kind_e;

  // Data columns: all weight-3 patterns first, then weight-5 ones.
  function automatic logic [DATA_W-1:0][CHK_W-1:0] build_cols();
    logic [DATA_W-1:0][CHK_W-1:0] c;
    int n;
    c = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 1; v < (1 << CHK_W); v++) begin
        logic [CHK_W-1:0] vb;
        vb = CHK_W'(v);
        if ($countones(vb) == w && n < DATA_W) begin
          c[n] = vb;
          n++;
        end
      end
    end
    return c;
  endfunction

  localparam logic [DATA_W-1:0][CHK_W-1:0] H_COLS = build_cols();

  function automatic logic [CHK_W-1:0] make_chk(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) s = s ^ H_COLS[i];
    end
    return s;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  input  logic [CW_W-1:0]   flip,
  output logic [DATA_W-1:0] data_out,
  output logic [CHK_W-1:0]  chk_out
);
  logic [CW_W-1:0] cw;

  always_comb begin
    cw = {make_chk(data_in), data_in} ^ flip;
  end

  assign data_out = cw[DATA_W-1:0];
  assign chk_out  = cw[CW_W-1:DATA_W];
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [DATA_W-1:0] fixed,
  output syn_kind_e         kind
);
  logic [CHK_W-1:0] syn;
  logic             hit;

  always_comb begin
    syn   = en ? (chk ^ make_chk(data)) : '0;
    fixed = data;
    hit   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (syn == H_COLS[i]) begin
        fixed[i] = ~data[i];
        hit      = 1'b1;
      end
    end
    if (syn == '0)          kind = SYN_CLEAN;
    else if ($onehot(syn))  kind = SYN_CHK;
    else if (hit)           kind = SYN_DATA;
    else                    kind = SYN_MULTI;
  end
endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              chk_en,
  output logic [DATA_W-1:0] rdata,
  output logic [CHK_W-1:0]  rchk
);
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CHK_W-1:0]  mem_c [DEPTH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rst_n) begin
        mem_d[e] <= '0;
        mem_c[e] <= '0;
      end else if (we && widx == IDX_W'(e)) begin
        mem_d[e] <= wdata;
        mem_c[e] <= wchk;
      end
    end
  end

  assign rdata = mem_d[ridx];
  // Check-bit column is only driven when a check is wanted.
  assign rchk  = chk_en ? mem_c[ridx] : '0;
endmodule

// File: rtl/ecc_array_ctrl.sv
module ecc_array_ctrl
  import ecc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_cow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW_W-1:0]   req_inject,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_valid,
  output logic [1:0]        err_class,
  output logic [IDX_W-1:0]  err_idx
);
  typedef enum logic {S_IDLE, S_WRITE} state_e;

  state_e            state_q;
  logic              mode_q;
  logic              pre_chk, acc, rd_acc, wr_acc, dec_en;
  logic [DATA_W-1:0] st_data, fixed, enc_data;
  logic [CHK_W-1:0]  st_chk, enc_chk;
  syn_kind_e         kind;
  err_class_e        cls;

  logic              rsp_valid_q, err_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  err_class_e        err_class_q;
  logic [IDX_W-1:0]  err_idx_q;

  assign pre_chk   = (state_q == S_IDLE) && req_valid && req_we && mode_q;
  assign req_ready = !pre_chk;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_we;
  assign wr_acc    = acc && req_we;
  assign dec_en    = pre_chk || (rd_acc && !mode_q);

  ecc_enc u_enc (
    .data_in  (req_wdata),
    .flip     (req_inject),
    .data_out (enc_data),
    .chk_out  (enc_chk)
  );

  ecc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_acc),
    .widx   (req_idx),
    .wdata  (enc_data),
    .wchk   (enc_chk),
    .ridx   (req_idx),
    .chk_en (dec_en),
    .rdata  (st_data),
    .rchk   (st_chk)
  );

  ecc_dec u_dec (
    .en    (dec_en),
    .data  (st_data),
    .chk   (st_chk),
    .fixed (fixed),
    .kind  (kind)
  );

  always_comb begin
    unique case (kind)
      SYN_CHK:   cls = ERR_FAST;
      SYN_DATA:  cls = pre_chk ? ERR_SLOW : ERR_FAST;
      SYN_MULTI: cls = ERR_UNCORR;
      default:   cls = ERR_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      mode_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      err_valid_q <= 1'b0;
      err_class_q <= ERR_NONE;
      err_idx_q   <= '0;
    end else begin
      if (state_q == S_IDLE && !req_valid) mode_q <= mode_cow;
      if (pre_chk)                         state_q <= S_WRITE;
      else if (state_q == S_WRITE && acc)  state_q <= S_IDLE;

      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= mode_q ? st_data : fixed;

      err_valid_q <= dec_en && (kind != SYN_CLEAN);
      err_class_q <= dec_en ? cls : ERR_NONE;
      if (dec_en) err_idx_q <= req_idx;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign err_valid = err_valid_q;
  assign err_class = err_class_q;
  assign err_idx   = err_idx_q;

  // R5: a stall lasts exactly one cycle
  p_stall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  // R5: the stalled write is still presented when it is accepted
  p_hold_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WRITE |-> (req_valid && req_we));

  // R2: reads are never stalled and always answer in the next cycle
  p_read_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |-> req_ready);
  p_read_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  // R4: a read in write-checking mode raises no report
  p_cow_read_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && mode_q && state_q == S_IDLE) |=> !err_valid);

  // R8: mode is frozen while a write is in progress
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRITE || req_valid) |=> $stable(mode_q));

  // R10: every pulse carries a class
  p_class_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_class != 2'd0));
endmodule

// File: tb/tb_ecc_array_ctrl.sv
module tb_ecc_array_ctrl;
  import ecc_pkg::*;

  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NV    = 17;
  localparam logic [7:0] NOP = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_cow = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [CW_W-1:0] req_inject = '0;
  logic req_ready, rsp_valid, err_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [1:0] err_class;
  logic [IDX_W-1:0] err_idx;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_array_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_cow(mode_cow),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_idx(req_idx), .req_wdata(req_wdata), .req_inject(req_inject),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_valid(err_valid), .err_class(err_class), .err_idx(err_idx)
  );

  // {cow, we, idx[3:0], data[63:0], flip0[7:0], flip1[7:0], class[1:0]}
  localparam logic [87:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd1, 64'hDEAD_BEEF_0000_1111, NOP,   NOP,   2'd0},
    {1'b0, 1'b0, 4'd1, 64'hDEAD_BEEF_0000_1111, NOP,   NOP,   2'd0},
    {1'b0, 1'b1, 4'd2, 64'h0123_4567_89AB_CDEF, 8'd5,  NOP,   2'd0},
    {1'b0, 1'b0, 4'd2, 64'h0123_4567_89AB_CDEF, NOP,   NOP,   2'd1},
    {1'b0, 1'b1, 4'd3, 64'hFFFF_0000_FFFF_0000, 8'd66, NOP,   2'd0},
    {1'b0, 1'b0, 4'd3, 64'hFFFF_0000_FFFF_0000, NOP,   NOP,   2'd1},
    {1'b0, 1'b1, 4'd4, 64'h0000_0000_0000_0000, 8'd3,  8'd40, 2'd0},
    {1'b0, 1'b0, 4'd4, 64'h0000_0100_0000_0008, NOP,   NOP,   2'd3},
    {1'b1, 1'b0, 4'd2, 64'h0123_4567_89AB_CDCF, NOP,   NOP,   2'd0},
    {1'b1, 1'b1, 4'd2, 64'h5555_AAAA_5555_AAAA, NOP,   NOP,   2'd2},
    {1'b0, 1'b0, 4'd2, 64'h5555_AAAA_5555_AAAA, NOP,   NOP,   2'd0},
    {1'b1, 1'b1, 4'd3, 64'h0000_0000_0000_0001, NOP,   NOP,   2'd1},
    {1'b1, 1'b1, 4'd4, 64'h8000_0000_0000_0000, NOP,   NOP,   2'd3},
    {1'b1, 1'b0, 4'd4, 64'h8000_0000_0000_0000, NOP,   NOP,   2'd0},
    {1'b1, 1'b1, 4'd5, 64'h0F0F_0F0F_0F0F_0F0F, 8'd10, NOP,   2'd0},
    {1'b1, 1'b1, 4'd5, 64'h2222_3333_4444_5555, NOP,   NOP,   2'd2},
    {1'b0, 1'b0, 4'd5, 64'h2222_3333_4444_5555, NOP,   NOP,   2'd0}
  };

  task automatic check(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    mode_cow = m;
  endtask

  task automatic run_op(bit cow, bit we, logic [IDX_W-1:0] idx, logic [63:0] d,
                        logic [7:0] p0, logic [7:0] p1, logic [1:0] ecls);
    logic [CW_W-1:0] m;
    m = '0;
    if (p0 != NOP) m[p0[6:0]] = 1'b1;
    if (p1 != NOP) m[p1[6:0]] = 1'b1;
    if (cow != mode_cow) set_mode(cow);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_idx = idx; req_wdata = d; req_inject = m;
    #1;
    if (we && cow) begin
      check(req_ready == 1'b0, "R5 stall", 72'(req_ready), 72'd0);
      @(negedge clk);
      check(req_ready == 1'b1, "R5 accept", 72'(req_ready), 72'd1);
      check(err_valid == (ecls != 2'd0), "R6 report", 72'(err_valid), 72'(ecls != 2'd0));
      if (ecls != 2'd0) begin
        check(err_class == ecls, "R6 class", 72'(err_class), 72'(ecls));
        check(err_idx == idx, "R6 index", 72'(err_idx), 72'(idx));
      end
      @(negedge clk);
      req_valid = 1'b0;
      check(err_valid == 1'b0, "R10 pulse", 72'(err_valid), 72'd0);
    end else begin
      check(req_ready == 1'b1, "R2/R7 ready", 72'(req_ready), 72'd1);
      @(negedge clk);
      req_valid = 1'b0;
      if (we) begin
        check(err_valid == 1'b0, "R7 no report", 72'(err_valid), 72'd0);
        check(rsp_valid == 1'b0, "R7 no response", 72'(rsp_valid), 72'd0);
      end else begin
        check(rsp_valid == 1'b1, "R2 response", 72'(rsp_valid), 72'd1);
        check(rsp_rdata == d, cow ? "R4 raw data" : "R3 data", 72'(rsp_rdata), 72'(d));
        check(err_valid == (ecls != 2'd0), cow ? "R4 quiet" : "R3 report",
              72'(err_valid), 72'(ecls != 2'd0));
        if (ecls != 2'd0)
          check(err_class == ecls, "R3 class", 72'(err_class), 72'(ecls));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready", 72'(req_ready), 72'd1);
    check(rsp_valid == 1'b0, "R9 rsp", 72'(rsp_valid), 72'd0);
    check(err_valid == 1'b0, "R9 err", 72'(err_valid), 72'd0);
    run_op(1'b0, 1'b0, 4'd0, 64'd0, NOP, NOP, 2'd0);   // R9 zero entry, R1 clean code
    run_op(1'b0, 1'b0, 4'd9, 64'd0, NOP, NOP, 2'd0);

    // Table walk: R1 to R7
    for (int k = 0; k < NV; k++) begin
      logic [87:0] v;
      v = VEC[k];
      run_op(v[87], v[86], v[85:82], v[81:18], v[17:10], v[9:2], v[1:0]);
    end

    // R8: mode change raised together with a request is deferred
    set_mode(1'b0);
    @(negedge clk);
    mode_cow = 1'b1;
    req_valid = 1'b1; req_we = 1'b1; req_idx = 4'd15;
    req_wdata = 64'hABCD_0000_1234_5678; req_inject = '0;
    #1;
    check(req_ready == 1'b1, "R8 old mode kept", 72'(req_ready), 72'd1);
    @(negedge clk);
    req_valid = 1'b0;
    // mode adopted at the next edge; a write now stalls
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_idx = 4'd15; req_wdata = 64'h1; req_inject = '0;
    #1;
    check(req_ready == 1'b0, "R8 new mode adopted", 72'(req_ready), 72'd0);
    @(negedge clk);
    check(err_valid == 1'b0, "R8 clean pre-check", 72'(err_valid), 72'd0);
    @(negedge clk);
    req_valid = 1'b0;
    run_op(1'b1, 1'b0, 4'd15, 64'h1, NOP, NOP, 2'd0);  // R1 boundary index

    // R3: a clean read after a fault read raises no second pulse (R10)
    run_op(1'b0, 1'b0, 4'd1, 64'hDEAD_BEEF_0000_1111, NOP, NOP, 2'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule